// File: doc/BRIEF.md
# Single-Cycle Core with Jump-and-Link

This block is a 32-bit processor core in which every instruction is fetched, decoded, executed and retired within one clock. It runs a small load/store subset: register-register arithmetic and logic, the same operations against a sign-extended 16-bit constant, word loads, word stores, and a jump-and-link. Instruction and data storage live outside the core. The core presents an instruction address and takes the word back in the same cycle. It presents a data address and takes read data back combinationally. Stores take effect at the next clock edge.

Jump-and-link is the one control transfer. It saves the address of the following instruction in register 31. It then moves fetch to a pseudo-direct target: the top four bits of the current PC, then the 26-bit field of the instruction, then two zero bits. To do this, the destination select and the writeback select each gain a third choice, and the next-PC logic gains a jump path.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, `dmem_we` is 0. At the first clock edge with `rst_n` low, the PC (`imem_addr`) becomes `RESET_PC` (0).
- R2: For every instruction other than jump-and-link, the next PC is the current PC plus 4.
- R3: Opcode 0 (bits 31:26) is the register form, with rs in bits 25:21, rt in 20:16, rd in 15:11 and the function code in 5:0. Function 0x20 gives add, 0x22 sub, 0x24 and, 0x25 or and 0x2A signed set-less-than. The result goes to rd.
- R4: Opcodes 0x08 (add), 0x0C (and) and 0x0D (or) combine rs with the sign-extended immediate in bits 15:0 and write the result to rt.
- R5: Opcode 0x23 drives `dmem_addr` = rs + sign-extended immediate and writes `dmem_rdata` into rt.
- R6: Opcode 0x2B asserts `dmem_we` with `dmem_addr` = rs + sign-extended immediate and `dmem_wdata` = rt. It writes no register.
- R7: Opcode 0x03 (jump-and-link) writes the current PC plus 4 into register 31 and does not store.
- R8: After opcode 0x03, the next PC is {PC[31:28], instruction[25:0], 2'b00}. The instruction that follows the jump in memory is not executed.
- R9: Register 0 always reads as zero. Writes to it have no effect.
- R10: An unknown opcode, or a register-form instruction with an unknown function code, writes no register, does not store, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe; the word is written at the next rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |

## Verification
Jump-and-link does two things at the same rising edge: it writes register 31 and it moves the PC. A fault in either one shows up at the first instruction of the target. The program therefore places a store of register 31 as the very first instruction at each jump target. It also places a second jump directly after a computation that reads register 31, and it ends with a jump whose target is itself. Each clock, a behavioural model in the bench predicts the PC, the store strobe, the store address and the store data, and compares them with the core's outputs. A wrong link value then appears as a store-data mismatch on the next cycle. A wrong target appears as a PC mismatch on that same cycle.

// File: rtl/sc_pkg.sv
// Shared encodings and control types for the single-cycle core.
// Assumes the fixed 32-bit instruction format with a 6-bit opcode.
package sc_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    localparam logic [OPC_W-1:0] OPC_REG  = 6'h00;
    localparam logic [OPC_W-1:0] OPC_JAL  = 6'h03;
    localparam logic [OPC_W-1:0] OPC_ADDI = 6'h08;
    localparam logic [OPC_W-1:0] OPC_ANDI = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI  = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_LW   = 6'h23;
    localparam logic [OPC_W-1:0] OPC_SW   = 6'h2B;

    localparam logic [FN_W-1:0] FN_ADD = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB = 6'h22;
    localparam logic [FN_W-1:0] FN_AND = 6'h24;
    localparam logic [FN_W-1:0] FN_OR  = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_op_e;

    typedef enum logic [1:0] {
        WB_ALU, WB_MEM, WB_LINK
    } wb_sel_e;

    typedef enum logic [1:0] {
        DST_RT, DST_RD, DST_LINK
    } dst_sel_e;

    typedef struct packed {
        logic     is_load;
        logic     is_store;
        logic     is_itype;
        logic     b_from_imm;
        logic     is_jal;
        logic     reg_we;
        alu_op_e  alu_op;
        wb_sel_e  wb_sel;
        dst_sel_e dst_sel;
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
// Instruction decoder: maps opcode and function code to the control bundle.
// Assumes nothing beyond the package encodings; unknown codes give a bundle
// that writes nothing and stores nothing.
module sc_decode
    import sc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  funct,
    output ctrl_t            ctl
);

    // Combinational decode of one instruction.
    always_comb begin
        ctl.is_load    = 1'b0;
        ctl.is_store   = 1'b0;
        ctl.is_itype   = 1'b0;
        ctl.b_from_imm = 1'b0;
        ctl.is_jal     = 1'b0;
        ctl.reg_we     = 1'b0;
        ctl.alu_op     = ALU_ADD;
        ctl.wb_sel     = WB_ALU;
        ctl.dst_sel    = DST_RT;
        case (opcode)
            OPC_REG: begin
                ctl.dst_sel = DST_RD;
                ctl.reg_we  = 1'b1;
                case (funct)
                    FN_ADD:  ctl.alu_op = ALU_ADD;
                    FN_SUB:  ctl.alu_op = ALU_SUB;
                    FN_AND:  ctl.alu_op = ALU_AND;
                    FN_OR:   ctl.alu_op = ALU_OR;
                    FN_SLT:  ctl.alu_op = ALU_SLT;
                    default: ctl.reg_we = 1'b0;
                endcase
            end
            OPC_ADDI, OPC_ANDI, OPC_ORI: begin
                ctl.is_itype   = 1'b1;
                ctl.b_from_imm = 1'b1;
                ctl.reg_we     = 1'b1;
                ctl.alu_op     = (opcode == OPC_ANDI) ? ALU_AND :
                                 (opcode == OPC_ORI)  ? ALU_OR  : ALU_ADD;
            end
            OPC_LW: begin
                ctl.is_load    = 1'b1;
                ctl.is_itype   = 1'b1;
                ctl.b_from_imm = 1'b1;
                ctl.reg_we     = 1'b1;
                ctl.wb_sel     = WB_MEM;
            end
            OPC_SW: begin
                ctl.is_store   = 1'b1;
                ctl.is_itype   = 1'b1;
                ctl.b_from_imm = 1'b1;
            end
            OPC_JAL: begin
                ctl.is_jal  = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.wb_sel  = WB_LINK;
                ctl.dst_sel = DST_LINK;
            end
            default: ;
        endcase
    end

    // Load, store and jump-and-link never share an instruction (R5, R6, R7).
    always_comb begin
        a_r5_kinds_exclusive: assert ($onehot0({ctl.is_load, ctl.is_store, ctl.is_jal}));
    end

endmodule

// File: rtl/sc_alu.sv
// Integer ALU: add, subtract, and, or, signed set-less-than.
// Assumes two's-complement operands of width W.
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    // Select one result per operation.
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
// Register file with two combinational read ports and one write port.
// Entry 0 is never written, so it reads as zero. Reset clears all entries.
module sc_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [NREG];

    // Clear on reset; otherwise write any entry except 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Read ports.
    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

    // R9: entry 0 keeps zero whatever is written to it.
    a_r9_zero_entry_held: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0] == '0);

endmodule

// File: rtl/sc_core.sv
// Single-cycle core top: PC, decode, register file, ALU, operand and
// writeback selection, next-PC logic including jump-and-link.
// Assumes XLEN = 32 and NREG = 32 (fixed instruction fields), and memories
// that return read data combinationally and write on the clock edge.
module sc_core
    import sc_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          NREG     = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic [XLEN-1:0] dmem_wdata,
    output logic            dmem_we,
    input  logic [XLEN-1:0] dmem_rdata
);

    localparam int AW       = $clog2(NREG);
    localparam int IMM_W    = 16;
    localparam int JIDX_W   = 26;
    localparam int PC_HI_W  = XLEN - JIDX_W - 2;
    localparam logic [AW-1:0] LINK_REG = AW'(NREG - 1);

    logic [XLEN-1:0] pc, pc_plus4, pc_next, imm_ext, alu_b, alu_y;
    logic [XLEN-1:0] rs_val, rt_val, wb_data;
    logic [AW-1:0]   rs_idx, rt_idx, rd_idx, rf_waddr;
    logic            rf_we;
    ctrl_t           ctl;

    // Instruction field split.
    assign rs_idx  = imem_data[25:21];
    assign rt_idx  = imem_data[20:16];
    assign rd_idx  = imem_data[15:11];
    assign imm_ext = {{(XLEN-IMM_W){imem_data[IMM_W-1]}}, imem_data[IMM_W-1:0]};

    sc_decode i_dec (
        .opcode (imem_data[31:26]),
        .funct  (imem_data[5:0]),
        .ctl    (ctl)
    );

    sc_regfile #(.W(XLEN), .NREG(NREG)) i_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (rs_idx),
        .ra_b  (rt_idx),
        .rd_a  (rs_val),
        .rd_b  (rt_val),
        .we    (rf_we),
        .wa    (rf_waddr),
        .wd    (wb_data)
    );

    // Second ALU operand: register or sign-extended constant.
    assign alu_b = ctl.b_from_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) i_alu (
        .a  (rs_val),
        .b  (alu_b),
        .op (ctl.alu_op),
        .y  (alu_y)
    );

    // Destination register select, including the fixed link register.
    always_comb begin
        case (ctl.dst_sel)
            DST_RD:   rf_waddr = rd_idx;
            DST_LINK: rf_waddr = LINK_REG;
            default:  rf_waddr = rt_idx;
        endcase
    end

    // Writeback value select: ALU, load data or return address.
    always_comb begin
        case (ctl.wb_sel)
            WB_MEM:  wb_data = dmem_rdata;
            WB_LINK: wb_data = pc_plus4;
            default: wb_data = alu_y;
        endcase
    end

    assign rf_we = ctl.reg_we;

    // Data memory side; no store while reset is held.
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctl.is_store & rst_n;

    // Next PC: sequential or pseudo-direct jump target.
    assign pc_plus4 = pc + XLEN'(4);
    assign pc_next  = ctl.is_jal ? {pc[XLEN-1 -: PC_HI_W], imem_data[JIDX_W-1:0], 2'b00}
                                 : pc_plus4;

    // PC register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= RESET_PC[XLEN-1:0];
        else        pc <= pc_next;
    end

    assign imem_addr = pc;

    // R1: no store strobe while reset is low.
    always_comb begin
        if (!rst_n) a_r1_quiet_in_reset: assert (!dmem_we);
    end

    // R2: sequential flow steps by one word.
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ctl.is_jal)) |-> (pc == $past(pc) + XLEN'(4)));

    // R8: jump target keeps the region bits and takes the 26-bit index.
    a_r8_jal_target: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ctl.is_jal)) |->
        (pc == {$past(pc[XLEN-1 -: PC_HI_W]), $past(imem_data[JIDX_W-1:0]), 2'b00}));

    // R6: a store never also writes a register.
    a_r6_store_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> !rf_we);

    // R7: jump-and-link writes the link register and never stores.
    a_r7_link_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.is_jal |-> (rf_we && (rf_waddr == LINK_REG) && !dmem_we));

endmodule

// File: tb/test_sc_core.sv
// Bench: runs a short program against a behavioural instruction-level model
// and compares PC and store outputs every clock, then checks stored results.
module test_sc_core;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 256;
    localparam int RUN_CYCLES = 60;
    localparam int WATCHDOG   = 2000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [MEM_WORDS];
    logic [31:0] dmem [MEM_WORDS];

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core i_sc_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[9:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    // Data memory write port.
    always @(posedge clk) begin
        if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;
    end

    // Encoders.
    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input int word_idx);
        return {6'h03, 26'(word_idx)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference model state.
    logic [31:0] m_pc;
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [MEM_WORDS];
    bit          m_after_jal;
    bit          m_first;

    // Compare outputs with the model, then advance the model one instruction.
    task automatic model_cycle();
        logic [31:0] ins, a, b, simm, res;
        logic [5:0]  op, fn;
        int          rs, rt, rd, dst;
        bit          wr, st, known;
        string       ptag;
        ptag = m_first ? "R1" : (m_after_jal ? "R8" : "R2");
        check(ptag, imem_addr, m_pc);
        ins  = imem[m_pc[9:2]];
        op   = ins[31:26];
        fn   = ins[5:0];
        rs   = int'(ins[25:21]);
        rt   = int'(ins[20:16]);
        rd   = int'(ins[15:11]);
        simm = {{16{ins[15]}}, ins[15:0]};
        a    = m_reg[rs];
        b    = m_reg[rt];
        wr = 0; st = 0; known = 1; dst = 0; res = '0;
        case (op)
            6'h00: begin
                dst = rd; wr = 1;
                case (fn)
                    6'h20: res = a + b;
                    6'h22: res = a - b;
                    6'h24: res = a & b;
                    6'h25: res = a | b;
                    6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: begin wr = 0; known = 0; end
                endcase
            end
            6'h08: begin dst = rt; wr = 1; res = a + simm; end
            6'h0C: begin dst = rt; wr = 1; res = a & simm; end
            6'h0D: begin dst = rt; wr = 1; res = a | simm; end
            6'h23: begin
                dst = rt; wr = 1; res = m_mem[(a + simm) >> 2];
                check("R5 load address", dmem_addr, a + simm);
            end
            6'h2B: st = 1;
            6'h03: begin dst = 31; wr = 1; res = m_pc + 32'd4; end
            default: known = 0;
        endcase
        check(known ? (op == 6'h03 ? "R7 no store" : "R6 strobe") : "R10 no store",
              {31'd0, dmem_we}, {31'd0, st});
        if (st) begin
            check("R6 store address", dmem_addr, a + simm);
            check(rt == 0 ? "R9 zero source" : "R6 store data", dmem_wdata, b);
            m_mem[(a + simm) >> 2] = b;
        end
        if (wr && dst != 0) m_reg[dst] = res;
        m_first     = 0;
        m_after_jal = (op == 6'h03);
        if (op == 6'h03) m_pc = {m_pc[31:28], ins[25:0], 2'b00};
        else             m_pc = m_pc + 32'd4;
    endtask

    // Program build, reset, lock-step run and final memory checks.
    initial begin
        int p;
        for (int i = 0; i < MEM_WORDS; i++) begin
            imem[i] = '0; dmem[i] = '0; m_mem[i] = '0;
        end
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        p = 0;
        imem[p++] = enc_i(6'h08, 1, 0, 16'd5);
        imem[p++] = enc_i(6'h08, 2, 0, 16'hFFFD);
        imem[p++] = enc_r(6'h20, 3, 1, 2);
        imem[p++] = enc_r(6'h22, 4, 1, 2);
        imem[p++] = enc_r(6'h24, 5, 1, 2);
        imem[p++] = enc_r(6'h25, 6, 1, 2);
        imem[p++] = enc_r(6'h2A, 7, 2, 1);
        imem[p++] = enc_i(6'h0C, 8, 2, 16'h00F0);
        imem[p++] = enc_i(6'h0D, 9, 0, 16'h1234);
        for (int r = 3; r <= 9; r++) imem[p++] = enc_i(6'h2B, r, 0, 16'(40 + 4*(r-3)));
        imem[p++] = enc_i(6'h23, 10, 0, 16'd40);
        imem[p++] = enc_i(6'h2B, 10, 0, 16'd68);
        imem[p++] = enc_i(6'h08, 0, 0, 16'd7);
        imem[p++] = enc_i(6'h2B, 0, 0, 16'd20);
        imem[p++] = 32'hFC00_0000;
        imem[p++] = enc_j(64);
        imem[p++] = enc_i(6'h08, 11, 0, 16'd99);
        imem[p++] = enc_i(6'h2B, 11, 0, 16'd72);
        imem[64] = enc_i(6'h2B, 31, 0, 16'd24);
        imem[65] = enc_r(6'h20, 12, 31, 1);
        imem[66] = enc_i(6'h2B, 12, 0, 16'd28);
        imem[67] = enc_j(80);
        imem[80] = enc_i(6'h2B, 31, 0, 16'd32);
        imem[81] = enc_i(6'h23, 13, 0, 16'd24);
        imem[82] = enc_i(6'h08, 13, 13, 16'd1);
        imem[83] = enc_i(6'h2B, 13, 0, 16'd36);
        imem[84] = enc_j(84);

        m_pc = 32'h0; m_first = 1; m_after_jal = 0;
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R1 store strobe in reset", {31'd0, dmem_we}, 32'd0);
        end
        rst_n = 1'b1;
        for (int c = 0; c < RUN_CYCLES; c++) begin
            model_cycle();
            @(negedge clk);
        end
        check("R3 add",        dmem[10], 32'd2);
        check("R3 sub",        dmem[11], 32'd8);
        check("R3 and",        dmem[12], 32'd5);
        check("R3 or",         dmem[13], 32'hFFFF_FFFD);
        check("R3 slt",        dmem[14], 32'd1);
        check("R4 andi",       dmem[15], 32'h0000_00F0);
        check("R4 ori",        dmem[16], 32'h0000_1234);
        check("R5 load",       dmem[17], 32'd2);
        check("R9 r0 stays 0", dmem[5],  32'd0);
        check("R8 skipped",    dmem[18], 32'd0);
        check("R7 link first", dmem[6],  32'd88);
        check("R7 link used",  dmem[7],  32'd93);
        check("R7 link second",dmem[8],  32'd272);
        check("R5 reload",     dmem[9],  32'd89);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule